// File: doc/BRIEF.md
# Prioritized Interrupt Controller Register File

This block keeps the per-line interrupt state for 32 interrupt lines. Each line has an enable bit, a pending bit and a 2-bit software priority. A processor-side register bus, one full word per access, reaches this state through four write-one registers and eight priority words. The four write-one registers set enables, clear enables, set pendings and clear pendings. A rising edge on an interrupt input marks that line pending. An acknowledge from the core, which carries a line number, clears that line's pending bit.

In every cycle the block combines the registered state and picks one winner. The winner is the enabled, pending line with the smallest priority value. When two lines share that value, the lower line number wins. The block outputs the winner's number and priority with a valid flag. Exception entry, stacking and comparison against the running level are left to the core.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset every register reads 0x00000000: all lines are disabled, none is pending, every priority is 0, and `sel_valid` is low.
- R2: Enable set register at offset 0x100, enable clear register at offset 0x180. A 1 written to bit n sets or clears the enable of line n. A 0 leaves the bit unchanged. A read of either register returns the current enable vector.
- R3: Pending set register at offset 0x200, pending clear register at offset 0x280. These work the same way for the pending bits, and a read of either returns the pending vector.
- R4: Priority word k is at offset 0x400 + 4k, for k = 0..7. Byte j of word k (bits 8j+7:8j) belongs to line 4k+j, and byte lane 0 is always bits 7:0. The priority field is bits 7:6 of that byte. The other six bits read as 0 and ignore writes.
- R5: Among lines that are enabled and pending, the one with the smallest priority value is reported on `sel_id`. Value 0 is the most urgent.
- R6: When several enabled pending lines share the smallest priority value, the lowest-numbered line is reported.
- R7: A 0-to-1 transition on `irq_in[n]` sets pending bit n one clock later. A line held high does not set its pending bit again after the bit is cleared.
- R8: `ack_valid` with `ack_id` = n clears pending bit n at the next clock edge. If a pending-set write for that line falls in the same cycle, the bit ends up set.
- R9: An access with `bus_size` other than word (0 = byte, 1 = halfword, 2 = word, 3 = reserved) leaves all state unchanged. Such an access returns read data 0 and drives `bus_err` high during the following cycle only.
- R10: A word access to an offset that is not mapped, or to an address that is not word aligned, reads 0 and changes no state.
- R11: `sel_prio` gives the winner's priority. `sel_valid` is low whenever no line is both enabled and pending, so a pending line that is disabled is never reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset from the block base |
| bus_size | input | 2 | Access size: 0 byte, 1 halfword, 2 word |
| bus_wdata | input | 32 | Write data, little-endian lanes |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| bus_err | output | 1 | Sub-word access was seen in the previous cycle |
| irq_in | input | 32 | Interrupt request lines |
| ack_valid | input | 1 | Core acknowledges a line |
| ack_id | input | 5 | Line being acknowledged |
| sel_valid | output | 1 | A line is enabled and pending |
| sel_id | output | 5 | Number of the selected line |
| sel_prio | output | 2 | Priority of the selected line |

## Verification
The bench gives two lines the same urgency and checks that the lower-numbered one wins. A design that scans from the wrong end, or that takes the later line on a tie, reports line 20 where line 10 is expected. It also checks that a disabled pending line is skipped, which catches a selector that looks only at pending bits.

A byte write of all ones to the enable set register must leave the enables at 0. A design that merges the partial write would enable every line. The bench holds an interrupt input high across a software clear, which catches a level-sensitive latch that keeps setting the pending bit again. It also sends an acknowledge in the same cycle as a pending-set write, so that a design that lets the acknowledge win shows a cleared bit.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;

  localparam int unsigned LANES_PER_WORD = 4;
  localparam int unsigned WORD_BITS      = 32;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } acc_size_e;

  typedef enum logic [2:0] {
    RG_NONE     = 3'd0,
    RG_SET_EN   = 3'd1,
    RG_CLR_EN   = 3'd2,
    RG_SET_PEND = 3'd3,
    RG_CLR_PEND = 3'd4,
    RG_PRIO     = 3'd5
  } reg_sel_e;

  localparam logic [11:0] OFS_SET_EN   = 12'h100;
  localparam logic [11:0] OFS_CLR_EN   = 12'h180;
  localparam logic [11:0] OFS_SET_PEND = 12'h200;
  localparam logic [11:0] OFS_CLR_PEND = 12'h280;
  localparam logic [11:0] OFS_PRIO     = 12'h400;

endpackage

// File: rtl/irq_bus_decode.sv
module irq_bus_decode
  import irq_prio_pkg::*;
#(
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned PRIO_REGS = 8,
  localparam int unsigned IDX_W    = (PRIO_REGS > 1) ? $clog2(PRIO_REGS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [1:0]        bus_size,
  output reg_sel_e          hit,
  output logic [IDX_W-1:0]  prio_idx,
  output logic              wr_ok,
  output logic              rd_ok,
  output logic              bus_err
);

  localparam int unsigned BLK_LSB = IDX_W + 2;

  logic word_ok;
  logic aligned;
  logic in_prio;
  logic err_n;
  logic err_q;

  assign word_ok  = (acc_size_e'(bus_size) == SZ_WORD);
  assign aligned  = (bus_addr[1:0] == 2'b00);
  assign in_prio  = (bus_addr[ADDR_W-1:BLK_LSB] ==
                     ADDR_W'(OFS_PRIO) >> BLK_LSB);
  assign prio_idx = bus_addr[BLK_LSB-1:2];

  always_comb begin
    hit = RG_NONE;
    if (aligned) begin
      if (bus_addr == ADDR_W'(OFS_SET_EN))        hit = RG_SET_EN;
      else if (bus_addr == ADDR_W'(OFS_CLR_EN))   hit = RG_CLR_EN;
      else if (bus_addr == ADDR_W'(OFS_SET_PEND)) hit = RG_SET_PEND;
      else if (bus_addr == ADDR_W'(OFS_CLR_PEND)) hit = RG_CLR_PEND;
      else if (in_prio)                           hit = RG_PRIO;
    end
  end

  assign wr_ok = bus_sel &&  bus_wr && word_ok && (hit != RG_NONE);
  assign rd_ok = bus_sel && !bus_wr && word_ok && (hit != RG_NONE);

  always_comb begin
    err_n = bus_sel && !word_ok;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= err_n;
  end

  assign bus_err = err_q;

  // R9: a sub-word access is flagged in the following cycle
  a_r9_err_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && (bus_size != 2'd2)) |=> bus_err);

  // R9: the flag lasts one cycle only without a new sub-word access
  a_r9_err_single: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_sel && (bus_size != 2'd2)) |=> !bus_err);

endmodule

// File: rtl/irq_state_regs.sv
module irq_state_regs
  import irq_prio_pkg::*;
#(
  parameter int unsigned LINES     = 32,
  parameter int unsigned PRIO_W    = 2,
  localparam int unsigned PRIO_REGS = LINES / LANES_PER_WORD,
  localparam int unsigned IDX_W    = (PRIO_REGS > 1) ? $clog2(PRIO_REGS) : 1,
  localparam int unsigned ID_W     = $clog2(LINES)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [LINES-1:0]             irq_in,
  input  logic                         wr_ok,
  input  reg_sel_e                     hit,
  input  logic [IDX_W-1:0]             prio_idx,
  input  logic [LINES-1:0]             wdata,
  input  logic                         ack_valid,
  input  logic [ID_W-1:0]              ack_id,
  output logic [LINES-1:0]             en_q,
  output logic [LINES-1:0]             pend_q,
  output logic [LINES-1:0][PRIO_W-1:0] prio_q
);

  logic [LINES-1:0]             irq_q;
  logic [LINES-1:0]             rise;
  logic [LINES-1:0]             en_n;
  logic [LINES-1:0]             pend_n;
  logic [LINES-1:0]             set_mask;
  logic [LINES-1:0]             clr_mask;
  logic [LINES-1:0]             ack_mask;
  logic [LINES-1:0][PRIO_W-1:0] prio_n;
  logic [PRIO_REGS-1:0]         prio_we;
  logic                         en_we;
  logic                         pend_we;
  logic                         sw_set_pend;

  // input edge history
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= '0;
    else        irq_q <= irq_in;
  end

  assign rise = irq_in & ~irq_q;

  // enable state
  always_comb begin
    en_we = wr_ok && ((hit == RG_SET_EN) || (hit == RG_CLR_EN));
    en_n  = en_q;
    if (hit == RG_SET_EN) en_n = en_q | wdata;
    else if (hit == RG_CLR_EN) en_n = en_q & ~wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= '0;
    else if (en_we) en_q <= en_n;
  end

  // pending state: set sources dominate clear sources
  always_comb begin
    sw_set_pend = wr_ok && (hit == RG_SET_PEND);
    ack_mask    = '0;
    if (ack_valid) ack_mask[ack_id] = 1'b1;
    set_mask = (sw_set_pend ? wdata : '0) | rise;
    clr_mask = ((wr_ok && (hit == RG_CLR_PEND)) ? wdata : '0) | ack_mask;
    pend_n   = (pend_q & ~clr_mask) | set_mask;
    pend_we  = (|set_mask) || (|clr_mask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pend_q <= '0;
    else if (pend_we) pend_q <= pend_n;
  end

  // priority words: one clock enable per word, one field per byte lane
  generate
    for (genvar k = 0; k < PRIO_REGS; k++) begin : g_word
      assign prio_we[k] = wr_ok && (hit == RG_PRIO) && (prio_idx == IDX_W'(k));
      for (genvar j = 0; j < LANES_PER_WORD; j++) begin : g_lane
        localparam int unsigned LINE = k * LANES_PER_WORD + j;
        assign prio_n[LINE] = wdata[8*j+7 -: PRIO_W];
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n)          prio_q[LINE] <= '0;
          else if (prio_we[k]) prio_q[LINE] <= prio_n[LINE];
        end
      end
    end
  endgenerate

  // R7: every rising input edge is recorded as pending
  a_r7_edge_sets_pend: assert property (@(posedge clk) disable iff (!rst_n)
    (|rise) |=> ((pend_q & $past(rise)) == $past(rise)));

  // R8: an acknowledge with no competing set clears the line
  a_r8_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_valid && !sw_set_pend && !rise[ack_id]) |=> !pend_q[$past(ack_id)]);

  // R8: a software set in the same cycle as an acknowledge wins
  a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_valid && sw_set_pend && wdata[ack_id]) |=> pend_q[$past(ack_id)]);

  // R2: enables move only through the enable registers
  a_r2_en_bus_only: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_ok && ((hit == RG_SET_EN) || (hit == RG_CLR_EN))) |=> $stable(en_q));

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
  parameter int unsigned LINES  = 32,
  parameter int unsigned PRIO_W = 2,
  localparam int unsigned ID_W  = $clog2(LINES)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [LINES-1:0]             en,
  input  logic [LINES-1:0]             pend,
  input  logic [LINES-1:0][PRIO_W-1:0] prio,
  output logic                         sel_valid,
  output logic [ID_W-1:0]              sel_id,
  output logic [PRIO_W-1:0]            sel_prio
);

  logic [LINES-1:0] cand;

  assign cand = en & pend;

  // Scan from the top line down; "<=" lets a lower line take equal levels.
  always_comb begin
    sel_valid = 1'b0;
    sel_id    = '0;
    sel_prio  = '0;
    for (int i = LINES - 1; i >= 0; i--) begin
      if (cand[i] && (!sel_valid || (prio[i] <= sel_prio))) begin
        sel_valid = 1'b1;
        sel_id    = ID_W'(i);
        sel_prio  = prio[i];
      end
    end
  end

  // R11: a reported line is enabled and pending
  a_r11_valid_real: assert property (@(posedge clk) disable iff (!rst_n)
    sel_valid |-> (en[sel_id] && pend[sel_id]));

  // R11: nothing is reported when no candidate exists
  a_r11_idle_empty: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_valid |-> ((en & pend) == '0));

  // R5: the reported level belongs to the reported line
  a_r5_prio_of_winner: assert property (@(posedge clk) disable iff (!rst_n)
    sel_valid |-> (sel_prio == prio[sel_id]));

endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_prio_pkg::*;
#(
  parameter int unsigned LINES  = 32,
  parameter int unsigned PRIO_W = 2,
  parameter int unsigned ADDR_W = 12,
  localparam int unsigned PRIO_REGS = LINES / LANES_PER_WORD,
  localparam int unsigned IDX_W  = (PRIO_REGS > 1) ? $clog2(PRIO_REGS) : 1,
  localparam int unsigned ID_W   = $clog2(LINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [1:0]        bus_size,
  input  logic [LINES-1:0]  bus_wdata,
  output logic [LINES-1:0]  bus_rdata,
  output logic              bus_err,
  input  logic [LINES-1:0]  irq_in,
  input  logic              ack_valid,
  input  logic [ID_W-1:0]   ack_id,
  output logic              sel_valid,
  output logic [ID_W-1:0]   sel_id,
  output logic [PRIO_W-1:0] sel_prio
);

  reg_sel_e                     hit;
  logic [IDX_W-1:0]             prio_idx;
  logic                         wr_ok;
  logic                         rd_ok;
  logic [LINES-1:0]             en_q;
  logic [LINES-1:0]             pend_q;
  logic [LINES-1:0][PRIO_W-1:0] prio_q;
  logic [PRIO_REGS-1:0][LINES-1:0] prio_word;

  irq_bus_decode #(
    .ADDR_W    (ADDR_W),
    .PRIO_REGS (PRIO_REGS)
  ) u_decode (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_sel  (bus_sel),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .bus_size (bus_size),
    .hit      (hit),
    .prio_idx (prio_idx),
    .wr_ok    (wr_ok),
    .rd_ok    (rd_ok),
    .bus_err  (bus_err)
  );

  irq_state_regs #(
    .LINES  (LINES),
    .PRIO_W (PRIO_W)
  ) u_state (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_in    (irq_in),
    .wr_ok     (wr_ok),
    .hit       (hit),
    .prio_idx  (prio_idx),
    .wdata     (bus_wdata),
    .ack_valid (ack_valid),
    .ack_id    (ack_id),
    .en_q      (en_q),
    .pend_q    (pend_q),
    .prio_q    (prio_q)
  );

  irq_arbiter #(
    .LINES  (LINES),
    .PRIO_W (PRIO_W)
  ) u_arb (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en_q),
    .pend      (pend_q),
    .prio      (prio_q),
    .sel_valid (sel_valid),
    .sel_id    (sel_id),
    .sel_prio  (sel_prio)
  );

  // priority words as seen on the bus: field at the top of each byte
  generate
    for (genvar k = 0; k < PRIO_REGS; k++) begin : g_rd_word
      for (genvar j = 0; j < LANES_PER_WORD; j++) begin : g_rd_lane
        assign prio_word[k][8*j+7 -: 8] =
          {prio_q[k*LANES_PER_WORD+j], {(8-PRIO_W){1'b0}}};
      end
    end
  endgenerate

  always_comb begin
    bus_rdata = '0;
    if (rd_ok) begin
      case (hit)
        RG_SET_EN, RG_CLR_EN:     bus_rdata = en_q;
        RG_SET_PEND, RG_CLR_PEND: bus_rdata = pend_q;
        RG_PRIO:                  bus_rdata = prio_word[prio_idx];
        default:                  bus_rdata = '0;
      endcase
    end
  end

  // R9: a sub-word write alters neither enables nor priorities
  a_r9_subword_inert: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && (bus_size != 2'd2)) |=> ($stable(en_q) && $stable(prio_q)));

  // R10: a write that decodes to nothing leaves the configuration alone
  a_r10_unmapped_inert: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && (hit == RG_NONE)) |=> ($stable(en_q) && $stable(prio_q)));

  // R9: sub-word reads return zero
  a_r9_subword_rd_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && (bus_size != 2'd2)) |-> (bus_rdata == '0));

endmodule

// File: tb/irq_prio_ctrl_tb.sv
`timescale 1ns/1ps
module irq_prio_ctrl_tb;

  logic        clk;
  logic        rst_n;
  logic        bus_sel;
  logic        bus_wr;
  logic [11:0] bus_addr;
  logic [1:0]  bus_size;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        bus_err;
  logic [31:0] irq_in;
  logic        ack_valid;
  logic [4:0]  ack_id;
  logic        sel_valid;
  logic [4:0]  sel_id;
  logic [1:0]  sel_prio;

  int checks;
  int failures;
  int cycles;

  localparam logic [11:0] A_SEN = 12'h100;
  localparam logic [11:0] A_CEN = 12'h180;
  localparam logic [11:0] A_SPD = 12'h200;
  localparam logic [11:0] A_CPD = 12'h280;
  localparam logic [11:0] A_PRI = 12'h400;

  irq_prio_ctrl u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_size  (bus_size),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .bus_err   (bus_err),
    .irq_in    (irq_in),
    .ack_valid (ack_valid),
    .ack_id    (ack_id),
    .sel_valid (sel_valid),
    .sel_id    (sel_id),
    .sel_prio  (sel_prio)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic summary_and_end();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    cycles = 0;
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        failures++;
        $display("FAIL watchdog: actual=%0d cycles expected=<100000", cycles);
        summary_and_end();
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic apply_reset();
    bus_sel = 0; bus_wr = 0; bus_addr = '0; bus_size = 2'd2; bus_wdata = '0;
    irq_in = '0; ack_valid = 0; ack_id = '0;
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic [1:0] sz = 2'd2);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d; bus_size = sz;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0; bus_size = 2'd2; bus_wdata = '0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d, input logic [1:0] sz = 2'd2);
    bus_sel = 1; bus_wr = 0; bus_addr = a; bus_size = sz;
    #1;
    d = bus_rdata;
    @(negedge clk);
    bus_sel = 0; bus_size = 2'd2;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    apply_reset();
    rd(A_SEN, d); chk("R1 enable after reset", d, 32'h0);
    rd(A_SPD, d); chk("R1 pending after reset", d, 32'h0);
    for (int k = 0; k < 8; k++) begin
      rd(A_PRI + 12'(4*k), d); chk("R1 priority after reset", d, 32'h0);
    end
    chk("R1 sel_valid after reset", {31'd0, sel_valid}, 32'd0);
    chk("R1 bus_err after reset", {31'd0, bus_err}, 32'd0);
  endtask

  task automatic t_enable();
    logic [31:0] d;
    apply_reset();
    wr(A_SEN, 32'h0000_00F0);
    wr(A_SEN, 32'h8000_0001);
    rd(A_SEN, d); chk("R2 set-enable accumulates", d, 32'h8000_00F1);
    wr(A_CEN, 32'h0000_0030);
    rd(A_CEN, d); chk("R2 clear-enable read shows state", d, 32'h8000_00C1);
    wr(A_CEN, 32'h0);
    rd(A_SEN, d); chk("R2 zero write no effect", d, 32'h8000_00C1);
  endtask

  task automatic t_pending();
    logic [31:0] d;
    apply_reset();
    wr(A_SPD, 32'h0F0F_0000);
    wr(A_CPD, 32'h0300_0000);
    rd(A_CPD, d); chk("R3 set/clear pending", d, 32'h0C0F_0000);
    rd(A_SEN, d); chk("R3 enables untouched by pending", d, 32'h0);
  endtask

  task automatic t_prio_layout();
    logic [31:0] d;
    apply_reset();
    wr(A_PRI + 12'h4, 32'hFFFF_FFFF);
    rd(A_PRI + 12'h4, d); chk("R4 only bits 7:6 per byte kept", d, 32'hC0C0_C0C0);
    wr(A_PRI + 12'h4, 32'h0000_0040);
    rd(A_PRI + 12'h4, d); chk("R4 lane 0 in bits 7:0", d, 32'h0000_0040);
    rd(A_PRI, d); chk("R4 other word untouched", d, 32'h0);
    // line 4 (word 1, lane 0) level 1, line 5 pending at level 0
    wr(A_SEN, 32'h0000_0030);
    wr(A_SPD, 32'h0000_0030);
    chk("R4 lane maps to line 5 (level 0)", {27'd0, sel_id}, 32'd5);
  endtask

  task automatic t_select();
    apply_reset();
    for (int k = 0; k < 8; k++) wr(A_PRI + 12'(4*k), 32'hC0C0_C0C0);
    wr(A_SEN, 32'hFFFF_FFFF);
    wr(A_PRI + 12'h8, 32'hC040_C0C0);    // line 10 -> level 1
    wr(A_PRI + 12'h14, 32'hC0C0_C040);   // line 20 -> level 1
    wr(A_SPD, 32'h4000_0000);            // line 30 at level 3
    chk("R5 single candidate", {27'd0, sel_id}, 32'd30);
    wr(A_SPD, 32'h0010_0400);            // lines 20 and 10 at level 1
    chk("R6 tie goes to lower line", {27'd0, sel_id}, 32'd10);
    chk("R11 priority of winner", {30'd0, sel_prio}, 32'd1);
    wr(A_CPD, 32'h0000_0400);
    chk("R5 next after clear", {27'd0, sel_id}, 32'd20);
    wr(A_PRI + 12'h1C, 32'hC000_C0C0);   // line 30 -> level 0
    chk("R5 most urgent wins", {27'd0, sel_id}, 32'd30);
    chk("R11 level 0 reported", {30'd0, sel_prio}, 32'd0);
    wr(A_CEN, 32'h4000_0000);
    chk("R11 disabled line skipped", {27'd0, sel_id}, 32'd20);
    wr(A_CEN, 32'h0010_0000);
    chk("R11 no candidate -> invalid", {31'd0, sel_valid}, 32'd0);
  endtask

  task automatic t_edge();
    logic [31:0] d;
    apply_reset();
    irq_in[5] = 1'b1;
    @(negedge clk);
    rd(A_SPD, d); chk("R7 rising edge sets pending", d, 32'h0000_0020);
    wr(A_CPD, 32'h0000_0020);
    @(negedge clk);
    rd(A_SPD, d); chk("R7 held level does not re-set", d, 32'h0);
    irq_in[5] = 1'b0;
    @(negedge clk);
    irq_in[5] = 1'b1;
    @(negedge clk);
    rd(A_SPD, d); chk("R7 second edge sets again", d, 32'h0000_0020);
  endtask

  task automatic t_ack();
    logic [31:0] d;
    apply_reset();
    wr(A_SEN, 32'h0000_0008);
    wr(A_SPD, 32'h0000_0008);
    chk("R8 line 3 selected", {sel_valid, 26'd0, sel_id}, {1'b1, 26'd0, 5'd3});
    ack_valid = 1; ack_id = 5'd3;
    @(negedge clk);
    ack_valid = 0;
    rd(A_SPD, d); chk("R8 ack clears pending", d, 32'h0);
    ack_valid = 1; ack_id = 5'd3;
    wr(A_SPD, 32'h0000_0008);
    ack_valid = 0;
    rd(A_SPD, d); chk("R8 set wins over ack", d, 32'h0000_0008);
  endtask

  task automatic t_subword();
    logic [31:0] d;
    apply_reset();
    wr(A_SEN, 32'hFFFF_FFFF, 2'd0);
    chk("R9 err after byte write", {31'd0, bus_err}, 32'd1);
    @(negedge clk);
    chk("R9 err one cycle", {31'd0, bus_err}, 32'd0);
    rd(A_SEN, d); chk("R9 byte write ignored", d, 32'h0);
    wr(A_PRI, 32'hFFFF_FFFF, 2'd1);
    rd(A_PRI, d); chk("R9 halfword write ignored", d, 32'h0);
    wr(A_SEN, 32'h0000_0001);
    rd(A_SEN, d, 2'd0); chk("R9 byte read returns zero", d, 32'h0);
    chk("R9 err after byte read", {31'd0, bus_err}, 32'd1);
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    apply_reset();
    wr(A_SEN, 32'h0000_0003);
    wr(12'h104, 32'hFFFF_FFFF);
    wr(12'h101, 32'hFFFF_FFFF);
    wr(12'h420, 32'hFFFF_FFFF);
    rd(A_SEN, d); chk("R10 unmapped write no effect", d, 32'h0000_0003);
    rd(12'h104, d); chk("R10 unmapped read zero", d, 32'h0);
    rd(12'h101, d); chk("R10 misaligned read zero", d, 32'h0);
    rd(12'h420, d); chk("R10 past priority words zero", d, 32'h0);
    for (int k = 0; k < 8; k++) begin
      rd(A_PRI + 12'(4*k), d); chk("R10 priorities untouched", d, 32'h0);
    end
    chk("R10 no error on word access", {31'd0, bus_err}, 32'd0);
  endtask

  initial begin
    checks = 0;
    failures = 0;
    t_reset();
    t_enable();
    t_pending();
    t_prio_layout();
    t_select();
    t_edge();
    t_ack();
    t_subword();
    t_unmapped();
    summary_and_end();
  end

endmodule